// File: doc/BRIEF.md
# Quota-Window Memory Request Throttler

This block sits in the request path between a memory request source and the command scheduler of a memory controller. It caps read and write traffic at a programmable budget of N transactions in every fixed window of M memory-clock cycles. Reads and writes draw on the same budget. The first N handshakes of a window pass straight through in the same cycle, whenever in the window they arrive, and that includes a back-to-back burst at the start of the window. After the budget is spent, the block lowers ready toward the source. The pending request stays valid at the source and is taken in the next window, so nothing is dropped.

N, M and a bypass bit are loaded through a one-cycle configuration write. The write lands in a shadow copy, and the shadow copy becomes active only at a window boundary. A window is therefore always judged against one consistent setting. A budget that covers the whole window, or the bypass bit, turns the block into a plain wire. A budget of zero shuts traffic off.

At each boundary the block latches two figures for the window that just closed: the number of accepted transactions and the number of cycles a request was held back by the budget. Firmware can read these to tell a saturated channel from a demand-limited one.

Top module: `qw_throttle`

## Requirements
- R1: Requests pass combinationally. mc_valid is req_valid gated by the throttle, req_ready is mc_ready gated by the throttle, and mc_write and mc_addr equal req_write and req_addr. Every source handshake is a downstream handshake in the same cycle, in the same order.
- R2: A window lasts M cycles of the active setting, and an M of 0 acts as 1. Windows run back to back from the release of reset.
- R3: At most N transactions are accepted in a window. A transaction counts only on a cycle with req_valid and req_ready both high. Reads (req_write=0) and writes (req_write=1) draw on one shared budget.
- R4: Once N transactions are accepted in a window, req_ready stays low for the rest of that window. A request held valid across the boundary is accepted in the first cycle of the next window when mc_ready is high.
- R5: An active N of 0 with bypass clear keeps req_ready and mc_valid low for the whole window.
- R6: With the bypass bit set, or with N greater than or equal to M, the throttle never blocks. A continuously valid source with mc_ready high is then accepted on every cycle of the window.
- R7: A configuration write (cfg_wr high for one cycle) is stored, and it takes effect only from the first cycle after the next window boundary. The window in which the write occurs is judged entirely with the previous setting.
- R8: At each window boundary, stat_accepted takes the number of transactions accepted in the window that closed. stat_stalls takes the number of cycles in that window with req_valid high while the throttle blocked, and cycles held off only by a low mc_ready are not counted. stat_strobe is high for exactly the first cycle of the next window.
- R9: While reset is asserted and after it is released, the active setting is the parameter defaults with bypass clear. The statistics read zero and stat_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | One-cycle write of the shadow setting |
| cfg_quota | input | 8 | Transaction budget N per window |
| cfg_window | input | 8 | Window length M in cycles |
| cfg_bypass | input | 1 | Force transparent operation |
| req_valid | input | 1 | Source request valid |
| req_write | input | 1 | Source request is a write (1) or read (0) |
| req_addr | input | ADDR_W | Source request address |
| req_ready | output | 1 | Request accepted this cycle when valid |
| mc_valid | output | 1 | Request valid toward the scheduler |
| mc_write | output | 1 | Write flag toward the scheduler |
| mc_addr | output | ADDR_W | Address toward the scheduler |
| mc_ready | input | 1 | Scheduler can take a request |
| stat_accepted | output | 8 | Transactions accepted in the last closed window |
| stat_stalls | output | 8 | Throttle-blocked request cycles in the last closed window |
| stat_strobe | output | 1 | High in the first cycle of each window as the figures update |

## Verification
A window counter that drifts shows up at the ports as a change in the spacing between stat_strobe pulses, and this spacing is measured against M. A budget counter that is wrong, or that is not cleared at the boundary, shows up within one window: req_ready falls on the wrong cycle, stat_accepted disagrees with the handshakes seen at the ports, or a window takes more than N transactions. A shadow setting applied early changes the count in the window that contains the write. A lost or duplicated request breaks the running sequence of addresses that arrives at the scheduler side.

// File: rtl/qw_pkg.sv
package qw_pkg;

  localparam int unsigned QW_CNT_W = 8;

  typedef logic [QW_CNT_W-1:0] qw_cnt_t;

  typedef struct packed {
    logic    bypass;
    qw_cnt_t quota;
    qw_cnt_t window;
  } qw_cfg_t;

  // Window length of zero is treated as a one-cycle window.
  function automatic qw_cnt_t qw_eff_window(qw_cnt_t w);
    return (w == '0) ? qw_cnt_t'(1) : w;
  endfunction

  // Budget covers the whole window, or bypass forced.
  function automatic logic qw_transparent(qw_cfg_t c);
    return c.bypass | (c.quota >= qw_eff_window(c.window));
  endfunction

endpackage

// File: rtl/qw_cfg_shadow.sv
module qw_cfg_shadow
  import qw_pkg::*;
#(
  parameter qw_cfg_t RESET_CFG = '{bypass: 1'b0, quota: 8'd2, window: 8'd8}
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_wr,
  input  qw_cfg_t cfg_in,
  input  logic    apply,
  output qw_cfg_t active
);

  qw_cfg_t pend_q, pend_d;
  qw_cfg_t act_q,  act_d;
  logic    pend_en, act_en;

  always_comb begin
    pend_en = cfg_wr;
    pend_d  = cfg_in;
    act_en  = apply;
    act_d   = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RESET_CFG;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RESET_CFG;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/qw_window_timer.sv
module qw_window_timer
  import qw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  qw_cnt_t win_len,
  output qw_cnt_t win_cnt,
  output logic    wrap
);

  qw_cnt_t cnt_q, cnt_d;
  qw_cnt_t last_idx;

  always_comb begin
    last_idx = qw_eff_window(win_len) - qw_cnt_t'(1);
    wrap     = (cnt_q >= last_idx);
    cnt_d    = wrap ? '0 : cnt_q + qw_cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign win_cnt = cnt_q;

endmodule

// File: rtl/qw_quota_gate.sv
module qw_quota_gate
  import qw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  qw_cfg_t act,
  input  logic    wrap,
  input  logic    fire,
  output logic    allow
);

  qw_cnt_t used_q, used_d;
  logic    used_en;
  logic    open_all;

  always_comb begin
    open_all = qw_transparent(act);
    allow    = open_all | (used_q < act.quota);
    used_en  = wrap | fire;
    used_d   = wrap ? '0 : used_q + qw_cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (used_en) begin
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/qw_stats.sv
module qw_stats
  import qw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wrap,
  input  logic    fire,
  input  logic    stall,
  output qw_cnt_t stat_accepted,
  output qw_cnt_t stat_stalls,
  output logic    stat_strobe
);

  qw_cnt_t acc_q, acc_d, acc_sum;
  qw_cnt_t stl_q, stl_d, stl_sum;
  qw_cnt_t rep_acc_q, rep_stl_q;
  logic    strobe_q;
  logic    rep_en;

  always_comb begin
    acc_sum = acc_q + qw_cnt_t'(fire);
    stl_sum = stl_q + qw_cnt_t'(stall);
    acc_d   = wrap ? '0 : acc_sum;
    stl_d   = wrap ? '0 : stl_sum;
    rep_en  = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stl_q <= '0;
    end else begin
      acc_q <= acc_d;
      stl_q <= stl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_acc_q <= '0;
      rep_stl_q <= '0;
    end else if (rep_en) begin
      rep_acc_q <= acc_sum;
      rep_stl_q <= stl_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= wrap;
    end
  end

  assign stat_accepted = rep_acc_q;
  assign stat_stalls   = rep_stl_q;
  assign stat_strobe   = strobe_q;

endmodule

// File: rtl/qw_throttle.sv
module qw_throttle
  import qw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DEF_QUOTA  = 2,
  parameter int unsigned DEF_WINDOW = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [QW_CNT_W-1:0]  cfg_quota,
  input  logic [QW_CNT_W-1:0]  cfg_window,
  input  logic                 cfg_bypass,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  output logic                 mc_valid,
  output logic                 mc_write,
  output logic [ADDR_W-1:0]    mc_addr,
  input  logic                 mc_ready,
  output logic [QW_CNT_W-1:0]  stat_accepted,
  output logic [QW_CNT_W-1:0]  stat_stalls,
  output logic                 stat_strobe
);

  localparam qw_cfg_t RESET_CFG = '{
    bypass: 1'b0,
    quota:  qw_cnt_t'(DEF_QUOTA),
    window: qw_cnt_t'(DEF_WINDOW)
  };

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_n_sync;

  generate
    if (RST_STAGES <= 1) begin : g_rst_one
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_n_sync = rs_q;
    end else begin : g_rst_chain
      logic [RST_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = rs_q[RST_STAGES-1];
    end
  endgenerate

  qw_cfg_t cfg_wdata;
  qw_cfg_t act_cfg;
  qw_cnt_t win_cnt;
  logic    wrap;
  logic    allow;
  logic    fire;
  logic    stall;

  assign cfg_wdata = '{bypass: cfg_bypass, quota: cfg_quota, window: cfg_window};

  qw_cfg_shadow #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cfg_wr (cfg_wr),
    .cfg_in (cfg_wdata),
    .apply  (wrap),
    .active (act_cfg)
  );

  qw_window_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .win_len (act_cfg.window),
    .win_cnt (win_cnt),
    .wrap    (wrap)
  );

  qw_quota_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .act   (act_cfg),
    .wrap  (wrap),
    .fire  (fire),
    .allow (allow)
  );

  qw_stats u_stats (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .wrap          (wrap),
    .fire          (fire),
    .stall         (stall),
    .stat_accepted (stat_accepted),
    .stat_stalls   (stat_stalls),
    .stat_strobe   (stat_strobe)
  );

  always_comb begin
    req_ready = mc_ready & allow;
    mc_valid  = req_valid & allow;
    mc_write  = req_write;
    mc_addr   = req_addr;
    fire      = req_valid & req_ready;
    stall     = req_valid & ~allow;
  end

endmodule

// File: rtl/qw_throttle_chk.sv
module qw_throttle_chk
  import qw_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    req_valid,
  input logic    req_ready,
  input logic    mc_valid,
  input logic    mc_ready,
  input logic    wrap,
  input qw_cnt_t win_cnt,
  input qw_cfg_t act_cfg,
  input logic    stat_strobe
);

  // Independent tally of handshakes inside the current window.
  qw_cnt_t seen_q;
  logic    hs;

  assign hs = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= '0;
    else if (wrap) seen_q <= '0;
    else if (hs)   seen_q <= seen_q + qw_cnt_t'(1);
  end

  a_r1_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mc_valid |-> req_valid);

  a_r1_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mc_ready);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !qw_transparent(act_cfg)) |-> (seen_q < act_cfg.quota));

  a_r5_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.quota == '0 && !act_cfg.bypass) |-> (!req_ready && !mc_valid));

  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_cfg));

  a_r2_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (win_cnt == '0));

  a_r8_strobe_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strobe |-> (win_cnt == '0));

endmodule

bind qw_throttle qw_throttle_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mc_valid    (mc_valid),
  .mc_ready    (mc_ready),
  .wrap        (wrap),
  .win_cnt     (win_cnt),
  .act_cfg     (act_cfg),
  .stat_strobe (stat_strobe)
);

// File: tb/tb_qw_throttle.sv
`timescale 1ns/1ps
module tb_qw_throttle;

  localparam int AW = 16;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [7:0]    cfg_quota, cfg_window;
  logic          cfg_bypass;
  logic          req_valid, req_write, req_ready;
  logic [AW-1:0] req_addr, mc_addr;
  logic          mc_valid, mc_write, mc_ready;
  logic [7:0]    stat_accepted, stat_stalls;
  logic          stat_strobe;

  always #2 clk = ~clk;

  qw_throttle #(.ADDR_W(AW), .DEF_QUOTA(2), .DEF_WINDOW(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_quota(cfg_quota),
    .cfg_window(cfg_window), .cfg_bypass(cfg_bypass), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .mc_valid(mc_valid), .mc_write(mc_write), .mc_addr(mc_addr),
    .mc_ready(mc_ready), .stat_accepted(stat_accepted),
    .stat_stalls(stat_stalls), .stat_strobe(stat_strobe)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit demand = 0, rand_mode = 0, mr_set = 1;
  bit last_fire = 0, chk_win = 0;
  int seq = 0, mon_seq = 0, win_acc = 0, quota_lim = 0;

  // {quota, window, bypass, mc_ready, expected accepted, expected stalls}
  localparam int VEC [NV][6] = '{
    '{2,  8, 0, 1, 2, 6},
    '{1,  4, 0, 1, 1, 3},
    '{8,  8, 0, 1, 8, 0},
    '{10, 4, 0, 1, 4, 0},
    '{1,  8, 1, 1, 8, 0},
    '{0,  6, 0, 1, 0, 6},
    '{5, 16, 0, 1, 5, 11},
    '{4,  8, 0, 0, 0, 0},
    '{2,  3, 0, 1, 2, 1},
    '{7,  8, 0, 1, 7, 1}
  };

  task automatic chk_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!stat_strobe);
  endtask

  task automatic set_cfg(int q, int m, int b);
    @(posedge clk); #1;
    cfg_quota = 8'(q); cfg_window = 8'(m); cfg_bypass = 1'(b); cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  // Request source: holds a request until it is accepted; addresses are a running sequence.
  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; mc_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (last_fire) seq++;
      if (!req_valid || last_fire)
        req_valid = rand_mode ? 1'($urandom_range(0, 1)) : demand;
      mc_ready  = rand_mode ? 1'($urandom_range(0, 1)) : mr_set;
      req_addr  = AW'(seq);
      req_write = seq[0];
    end
  end

  // Monitor: ordering, same-cycle handshake, per-window tally.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      last_fire = req_valid && req_ready;
      chk_eq("R1 handshake", int'(mc_valid && mc_ready), int'(last_fire));
      if (mc_valid && mc_ready) begin
        chk_eq("R1 order addr", int'(mc_addr), mon_seq % 65536);
        chk_eq("R1 order write", int'(mc_write), mon_seq % 2);
        mon_seq++;
      end
      if (stat_strobe) begin
        if (chk_win) begin
          chk_eq("R8 accepted tally", int'(stat_accepted), win_acc);
          chk_eq("R3 window within quota", int'(win_acc <= quota_lim), 1);
        end
        win_acc = 0;
      end
      if (last_fire) win_acc++;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R2 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_wr = 1'b0;
    cfg_quota = '0; cfg_window = '0; cfg_bypass = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R9 strobe in reset", int'(stat_strobe), 0);
    chk_eq("R9 accepted in reset", int'(stat_accepted), 0);
    chk_eq("R9 stalls in reset", int'(stat_stalls), 0);
    chk_eq("R9 mc_valid idle", int'(mc_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Default window is 8 cycles; no demand yields zero figures.
    wait_strobe();
    chk_eq("R9 idle accepted", int'(stat_accepted), 0);
    chk_eq("R9 idle stalls", int'(stat_stalls), 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!stat_strobe);
    chk_eq("R2 window length", n, 8);

    demand = 1;
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2]);
      mr_set = 1'(VEC[i][3]);
      wait_strobe();
      wait_strobe();
      chk_eq($sformatf("R3 R5 R6 vector %0d accepted", i), int'(stat_accepted), VEC[i][4]);
      chk_eq($sformatf("R8 vector %0d stalls", i), int'(stat_stalls), VEC[i][5]);
    end

    // Deferred setting: the window holding the write keeps quota 7.
    wait_strobe();
    set_cfg(2, 8, 0);
    wait_strobe();
    chk_eq("R7 old setting kept", int'(stat_accepted), 7);
    wait_strobe();
    chk_eq("R7 new setting applied", int'(stat_accepted), 2);

    // Burst at window start, then hold until the next window.
    set_cfg(3, 8, 0);
    wait_strobe();
    for (int i = 0; i <= 8; i++) begin
      chk_eq($sformatf("R4 ready cycle %0d", i), int'(req_ready), int'((i < 3) || (i == 8)));
      if (i < 8) @(negedge clk);
    end
    chk_eq("R8 strobe one window later", int'(stat_strobe), 1);
    @(negedge clk);
    chk_eq("R8 strobe single cycle", int'(stat_strobe), 0);

    // Random demand and backpressure with a fixed setting.
    set_cfg(3, 10, 0);
    wait_strobe();
    wait_strobe();
    quota_lim = 3;
    chk_win   = 1;
    rand_mode = 1;
    repeat (600) @(negedge clk);
    rand_mode = 0;
    wait_strobe();
    wait_strobe();
    chk_win = 0;
    chk_eq("R1 traffic flowed", int'(mon_seq > 100), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule